// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block divides a reference clock down to a square-wave bit clock. A 16-bit time constant, loaded one byte at a time, sets the length of each half of the output period. A down counter counts reference ticks. Each time the counter runs out, the output flip-flop toggles, a one-cycle tick is pulsed and the counter reloads. One half-period is therefore TC+2 reference ticks, and a full output period is 2×(TC+2) ticks. The output can serve as a transmit clock, a receive clock or the reference for a clock-recovery circuit.

The controlling logic raises `run` to start the generator. While `run` is low the counter holds and the output sits high. Each new start begins from a fresh load. The two constant bytes go into a staging register. The full 16-bit value is committed only at the next load or reload, and only once both bytes have been written since the last commit. This means the counter never sees a half-updated constant, and a write in mid-count leaves the half-period in progress untouched.

The controller has three named states:

- IDLE is entered on reset or whenever `run` is low.
- COUNT decrements the counter on each tick.
- WRAP toggles the output and reloads the counter.

The transitions are:

- *start* goes from IDLE to COUNT when `run` is seen high.
- *decrement* keeps COUNT in COUNT while the counter is non-zero or no tick arrives.
- *expire* goes from COUNT to WRAP on a tick with the counter at zero.
- *reload* goes from WRAP to COUNT on a tick.
- *halt* goes from any state to IDLE when `run` is low.

Top module: `brg_top`

## Requirements
- R1: After reset, `baud_out` is 1, `baud_tick` is 0, and the time constant in force is the parameter `RESET_TC`.
- R2: The clock edge that first samples `run` high in IDLE is the start edge. On it, the counter loads the constant in force and `baud_out` stays 1. The first toggle of `baud_out` happens on the (TC+2)-th clock edge after the start edge that samples `tick_en` high.
- R3: After the first toggle, `baud_out` toggles on every (TC+2)-th edge that samples `tick_en` high, so a full period is 2×(TC+2) ticks.
- R4: `baud_tick` is high for exactly the one cycle in which `baud_out` has just toggled while running. It is never high at any other time.
- R5: While running, an edge that samples `tick_en` low changes neither the counter nor `baud_out`.
- R6: An edge that samples `run` low returns the block to IDLE. On that edge `baud_out` becomes 1, the counter holds, and no tick is produced, even if a reload was due on the same edge.
- R7: A new start after a halt begins a full first half-period with `baud_out` at 1, whatever phase the halt interrupted.
- R8: On an edge where `wr_lo` is sampled high, `wr_data` is written into staging bits 7:0. On an edge where `wr_hi` is sampled high, `wr_data` is written into staging bits 15:8. Writes made mid-count do not change the length of the half-period in progress.
- R9: The staged value becomes the constant in force at the next start or reload only if both bytes have been written since the last commit. A lone byte write is never used until its partner byte is written.
- R10: A time constant of 0 gives the minimum half-period of 2 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Reference tick; the counter advances only on edges where it is high |
| run | input | 1 | Start/enable; low halts the generator with the output high |
| wr_lo | input | 1 | Write `wr_data` into the low byte of the staging register |
| wr_hi | input | 1 | Write `wr_data` into the high byte of the staging register |
| wr_data | input | CNT_W/2 | Byte to be staged |
| baud_out | output | 1 | Square-wave bit clock |
| baud_tick | output | 1 | One-cycle pulse on each output toggle |

## Verification
The bench uses the default 16-bit counter and sets `RESET_TC` to 3. With that setting, a run with no writes at all already gives a short, known half-period of 5 ticks. Small constants (0, 1, 2, 4) keep the minimum divide and several mid-count commits within a few dozen cycles. The constant 0x0100 places a 1 in the high byte, which confirms the byte lane positions in a run of a few hundred cycles. Tick patterns of every cycle and every third cycle, halts at arbitrary phases, and lone-byte writes cover the gating, restart and commit rules.

// File: rtl/brg_pkg.sv
package brg_pkg;

    // Controller states of the divider
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_WRAP  = 2'd2
    } brg_state_e;

endpackage

// File: rtl/brg_tc_stage.sv
// Byte-wise staging of the time constant, with a commit that requires both lanes.
module brg_tc_stage #(
    parameter int              CNT_W    = 16,
    parameter logic [CNT_W-1:0] RESET_TC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       lane_wr,
    input  logic [CNT_W/2-1:0] lane_data,
    input  logic             commit,
    output logic [CNT_W-1:0] tc_use
);
    localparam int LANES  = 2;
    localparam int LANE_W = CNT_W / LANES;

    logic [CNT_W-1:0] stage_q;
    logic [LANES-1:0] pend_q;
    logic [CNT_W-1:0] active_q;
    logic             all_pend;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[l*LANE_W +: LANE_W] <= RESET_TC[l*LANE_W +: LANE_W];
                pend_q[l]                   <= 1'b0;
            end else begin
                if (commit && all_pend) begin
                    pend_q[l] <= 1'b0;
                end
                if (lane_wr[l]) begin
                    stage_q[l*LANE_W +: LANE_W] <= lane_data;
                    pend_q[l]                   <= 1'b1;
                end
            end
        end
    end

    assign all_pend = &pend_q;

    // Value the counter loads at this edge: staged if complete, else the one in force
    always_comb begin
        tc_use = all_pend ? stage_q : active_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= RESET_TC;
        end else if (commit) begin
            active_q <= tc_use;
        end
    end

endmodule

// File: rtl/brg_fsm.sv
// Counter, output flip-flop and the controller that sequences them.
module brg_fsm
    import brg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] tc_use,
    output logic             commit,
    output logic             out_q,
    output logic             tick_q,
    output logic [CNT_W-1:0] cnt_q,
    output brg_state_e       st_q
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    brg_state_e st_d;
    logic       cnt_done;

    assign cnt_done = (cnt_q == CNT_ZERO);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state: halt has priority over every transition
    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = ST_IDLE;                       // halt
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_COUNT;        // start
                ST_COUNT: if (tick_en && cnt_done) st_d = ST_WRAP;   // expire
                ST_WRAP:  if (tick_en) st_d = ST_COUNT;              // reload
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // A new constant may be taken on a start or on a reload
    always_comb begin
        commit = run && ((st_q == ST_IDLE) || (st_q == ST_WRAP && tick_en));
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= CNT_ZERO;
            out_q  <= 1'b1;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (!run) begin
                out_q <= 1'b1;
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                        cnt_q <= tc_use;
                        out_q <= 1'b1;
                    end
                    ST_COUNT: begin
                        if (tick_en && !cnt_done) begin
                            cnt_q <= cnt_q - CNT_ONE;
                        end
                    end
                    ST_WRAP: begin
                        if (tick_en) begin
                            cnt_q  <= tc_use;
                            out_q  <= ~out_q;
                            tick_q <= 1'b1;
                        end
                    end
                    default: begin
                        out_q <= 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/brg_top.sv
module brg_top
    import brg_pkg::*;
#(
    parameter int               CNT_W    = 16,
    parameter logic [CNT_W-1:0] RESET_TC = CNT_W'(10)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               run,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [CNT_W/2-1:0] wr_data,
    output logic               baud_out,
    output logic               baud_tick
);
    logic [CNT_W-1:0] tc_use;
    logic             commit;
    logic [CNT_W-1:0] cnt_q;
    brg_state_e       st_q;

    brg_tc_stage #(
        .CNT_W    (CNT_W),
        .RESET_TC (RESET_TC)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_wr   ({wr_hi, wr_lo}),
        .lane_data (wr_data),
        .commit    (commit),
        .tc_use    (tc_use)
    );

    brg_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick_en (tick_en),
        .tc_use  (tc_use),
        .commit  (commit),
        .out_q   (baud_out),
        .tick_q  (baud_tick),
        .cnt_q   (cnt_q),
        .st_q    (st_q)
    );

endmodule

// File: rtl/brg_chk.sv
module brg_chk
    import brg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             tick_en,
    input logic             baud_out,
    input logic             baud_tick,
    input logic [CNT_W-1:0] cnt_q,
    input brg_state_e       st_q
);

    // R4
    tick_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> (baud_out != $past(baud_out)));

    // R4
    toggle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && (baud_out != $past(baud_out))) |-> baud_tick);

    // R6
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (baud_out && !baud_tick));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> $stable(cnt_q));

    // R5
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$past(tick_en) && ($past(st_q) != ST_IDLE))
            |-> ($stable(cnt_q) && $stable(baud_out) && !baud_tick));

    // R3
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && $past(tick_en) && ($past(st_q) == ST_COUNT) && ($past(cnt_q) != '0))
            |-> (cnt_q == ($past(cnt_q) - 1'b1)));

    // R2
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && ($past(st_q) == ST_IDLE)) |-> (baud_out && (st_q == ST_COUNT)));

endmodule

bind brg_top brg_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick_en   (tick_en),
    .baud_out  (baud_out),
    .baud_tick (baud_tick),
    .cnt_q     (cnt_q),
    .st_q      (st_q)
);

// File: tb/sim_brg_top.sv
`timescale 1ns/1ps
module sim_brg_top;
    localparam int          CNT_W    = 16;
    localparam logic [15:0] RST_TC   = 16'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       run = 1'b0;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_out;
    logic       baud_tick;

    int checks = 0;
    int fails  = 0;
    int edge_cnt = 0;
    bit finished = 1'b0;

    // scoreboard: expected edge index and output level of each toggle
    int exp_e[$];
    bit exp_l[$];

    // bench model of the constant, built from R8/R9
    logic [15:0] m_cur = RST_TC;
    logic [15:0] m_stage = RST_TC;
    bit          m_plo = 1'b0;
    bit          m_phi = 1'b0;
    bit          m_out = 1'b1;

    // planned mid-phase writes
    int         p_lo_c = -1;
    int         p_hi_c = -1;
    logic [7:0] p_lo_v = 8'h00;
    logic [7:0] p_hi_v = 8'h00;

    always #10 clk = ~clk;

    brg_top #(.CNT_W(CNT_W), .RESET_TC(RST_TC)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .baud_out(baud_out), .baud_tick(baud_tick)
    );

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    // monitor: pop and compare every tick
    always @(negedge clk) begin
        if (rst_n && baud_tick) begin
            checks++;
            if (exp_e.size() == 0) begin
                fails++;
                $display("FAIL R4 unexpected tick at edge %0d (actual tick=1, expected 0)", edge_cnt);
            end else begin
                int e;
                bit l;
                e = exp_e.pop_front();
                l = exp_l.pop_front();
                if (e != edge_cnt || l != baud_out) begin
                    fails++;
                    $display("FAIL R3 toggle: actual edge %0d level %0b, expected edge %0d level %0b",
                             edge_cnt, baud_out, e, l);
                end
            end
        end
    end

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic commit_model();
        if (m_plo && m_phi) begin
            m_cur = m_stage;
            m_plo = 1'b0;
            m_phi = 1'b0;
        end
    endtask

    task automatic idle_write(input bit hi, input logic [7:0] v);
        @(posedge clk); #1;
        wr_data = v; wr_hi = hi; wr_lo = !hi;
        if (hi) begin m_stage[15:8] = v; m_phi = 1'b1; end
        else    begin m_stage[7:0]  = v; m_plo = 1'b1; end
        @(posedge clk); #1;
        wr_lo = 1'b0; wr_hi = 1'b0;
    endtask

    // driver: runs the generator and pushes the expected toggles
    task automatic run_phase(input int ncyc, input int tdiv, input string req);
        int ticks;
        bit te;
        @(posedge clk); #1;
        run = 1'b1; tick_en = 1'b0;
        commit_model();                 // R9 commit at start
        m_out = 1'b1;
        ticks = 0;
        for (int c = 1; c <= ncyc; c++) begin
            @(posedge clk); #1;
            te = ((c % tdiv) == 0);
            tick_en = te;
            wr_lo = (c == p_lo_c);
            wr_hi = (c == p_hi_c);
            wr_data = (c == p_lo_c) ? p_lo_v : p_hi_v;
            if (te) begin
                ticks++;
                if (ticks == int'(m_cur) + 2) begin
                    ticks = 0;
                    commit_model();     // R9 commit at reload
                    m_out = ~m_out;
                    exp_e.push_back(edge_cnt + 1);
                    exp_l.push_back(m_out);
                end
            end
            if (c == p_lo_c) begin m_stage[7:0]  = p_lo_v; m_plo = 1'b1; end
            if (c == p_hi_c) begin m_stage[15:8] = p_hi_v; m_phi = 1'b1; end
        end
        @(posedge clk); #1;
        run = 1'b0; tick_en = 1'b1; wr_lo = 1'b0; wr_hi = 1'b0;
        p_lo_c = -1; p_hi_c = -1;
        repeat (3) @(posedge clk);
        #1;
        // R6 output high after halt
        check_bit({"R6 halt level after ", req}, baud_out, 1'b1);
        checks++;
        if (exp_e.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d toggles missing (actual 0, expected %0d)", req, exp_e.size(), exp_e.size());
            exp_e.delete();
            exp_l.delete();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check_bit("R1 reset baud_out", baud_out, 1'b1);
        check_bit("R1 reset baud_tick", baud_tick, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check_bit("R1 idle after reset", baud_out, 1'b1);

        // R1 R2 R3 R4: reset constant, tick every cycle
        run_phase(40, 1, "R2 R3 reset constant");

        // R6: long halt with ticks present, no toggles, counter holds
        repeat (10) @(posedge clk);
        #1;
        check_bit("R6 halted stays high", baud_out, 1'b1);

        // R10 R9: full write while idle, constant 0
        idle_write(1'b0, 8'h00);
        idle_write(1'b1, 8'h00);
        run_phase(20, 1, "R10 minimum constant");

        // R5: constant 2, tick every third cycle
        idle_write(1'b0, 8'h02);
        idle_write(1'b1, 8'h00);
        run_phase(60, 3, "R5 gated ticks");

        // R8: mid-count full write to 4 applies from the next reload
        p_lo_c = 7; p_lo_v = 8'h04;
        p_hi_c = 8; p_hi_v = 8'h00;
        run_phase(50, 1, "R8 mid-count write");

        // R9: lone low byte is not used
        p_lo_c = 5; p_lo_v = 8'h01;
        run_phase(40, 1, "R9 lone byte");

        // R9 R7: partner byte completes the pair mid-run; restart from fresh load
        p_hi_c = 10; p_hi_v = 8'h00;
        run_phase(37, 1, "R7 R9 partner byte");
        run_phase(23, 2, "R7 restart");

        // R8: high byte lane position, constant 0x0100
        idle_write(1'b0, 8'h00);
        idle_write(1'b1, 8'h01);
        run_phase(600, 1, "R8 high byte lane");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule